// File: doc/BRIEF.md
# Fixed-Size Flit Framer

The framer packs a byte stream of upper-layer packets into flow-control units that are always 256 bytes long, and on the receive side it checks these units and unpacks them. Packet boundaries play no part: bytes fill the 242-byte payload area in arrival order, and one packet may continue into the next unit. Once a unit has started, a payload slot with no input byte waiting gets a zero filler byte. From then on the rest of that payload area is filled with zeros and the unit closes, so the framer never stalls in the middle of a unit.

Behind the payload the transmitter appends an 8-byte CRC-64 over the payload, then six check bytes. The check bytes come from three byte groups that interleave across the unit. The receiver runs the same two computations over the bytes it gets and forwards only the payload bytes. After the last byte of each unit it reports one CRC verdict and one check-byte verdict. It only detects errors. It does no repair and no retry.

All four streaming edges are one byte wide and use a valid/ready handshake. A byte moves on a cycle where both valid and ready are high.

Top module: `flit_framer`

## Requirements
- R1: Every transmitted unit is exactly 256 bytes, numbered 0 to 255 in order of transfer. After byte 255 the next transferred byte is byte 0 of a new unit.
- R2: Bytes 0 to 241 carry the accepted input bytes in arrival order. A stream longer than 242 bytes continues into the following units with no byte lost or repeated.
- R3: Bytes 242 to 249 hold a CRC-64 over bytes 0 to 241, most significant byte first. It uses polynomial 0x42F0E1EBA9EA3693, a start value of all ones, MSB-first bit order and no final inversion.
- R4: No unit starts (tx_valid stays low at byte 0) while in_valid is low, so an input stream of exactly 242 bytes produces exactly one unit.
- R5: Once a unit has started, the first payload slot transferred with in_valid low carries 0x00. Every remaining payload slot of that unit also carries 0x00, and in_ready stays low until the unit ends.
- R6: Bytes 250 to 255 are, in order: G0 xor, G0 rotated xor, G1 xor, G1 rotated xor, G2 xor, G2 rotated xor. Group g holds unit bytes i < 250 with i mod 3 = g. The "xor" byte is the XOR of those bytes. The "rotated xor" byte is the XOR of each byte rotated left by (i/3) mod 8.
- R7: The receiver presents received bytes 0 to 241 on the payload port in order and never presents bytes 242 to 255.
- R8: One cycle after the last byte of a received unit is accepted, exactly one of crc_ok/crc_err and exactly one of fec_ok/fec_err is high, each for that single cycle.
- R9: crc_err means the received bytes 0 to 241 and 242 to 249 disagree under R3. fec_err means any of bytes 0 to 255 disagree under R6. So a flipped check byte gives crc_ok with fec_err, while a flipped payload or CRC byte gives both errors.
- R10: Backpressure from tx_ready or pl_ready stalls the affected path without losing or duplicating a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input packet byte available |
| in_data | input | 8 | Input packet byte |
| in_ready | output | 1 | Framer takes the input byte |
| tx_valid | output | 1 | Unit byte available for transmission |
| tx_data | output | 8 | Unit byte |
| tx_ready | input | 1 | Link takes the unit byte |
| rx_valid | input | 1 | Received unit byte available |
| rx_data | input | 8 | Received unit byte |
| rx_ready | output | 1 | Receiver takes the unit byte |
| pl_valid | output | 1 | Recovered payload byte available |
| pl_data | output | 8 | Recovered payload byte |
| pl_ready | input | 1 | Consumer takes the payload byte |
| crc_ok | output | 1 | One-cycle pulse: CRC of the finished unit matched |
| crc_err | output | 1 | One-cycle pulse: CRC of the finished unit mismatched |
| fec_ok | output | 1 | One-cycle pulse: check bytes of the finished unit matched |
| fec_err | output | 1 | One-cycle pulse: check bytes of the finished unit mismatched |

## Verification
The bench loops the transmit port back into the receiver. Each unit it sees is compared with a reference built from its own bitwise CRC and its own group and rotation arithmetic.

It targets the following corner cases:
- A stream that ends exactly on a full payload. A framer that opened a unit on an empty input would emit a spurious all-filler unit.
- A gap in the input in the middle of a unit. A framer that resumed data after the filler would corrupt the zero padding and shift later bytes.
- A stream spanning three units under periodic backpressure. This would expose dropped or duplicated bytes.
- Single-bit flips in a payload byte, a CRC byte and a check byte. These separate the coverage of the two checks. A receiver that ran the CRC over its own field, or left the CRC bytes out of the groups, would give the wrong pair of verdicts.

// File: rtl/flit_pkg.sv
`timescale 1ns/1ps
package flit_pkg;
  localparam int CRC_BYTES = 8;
  localparam int CHK_BYTES = 6;
  localparam logic [63:0] CRC64_POLY = 64'h42F0E1EBA9EA3693;

  // One byte of an MSB-first CRC-64, bits shifted out from the top
  function automatic logic [63:0] crc64_byte(input logic [63:0] c,
                                             input logic [7:0] b,
                                             input logic [63:0] poly);
    logic [63:0] r;
    r = c ^ {b, 56'b0};
    for (int i = 0; i < 8; i++) r = r[63] ? ((r << 1) ^ poly) : (r << 1);
    return r;
  endfunction

  // Left rotate of a byte by k places
  function automatic logic [7:0] rotl8(input logic [7:0] b, input logic [2:0] k);
    return (b << k) | (b >> (4'd8 - {1'b0, k}));
  endfunction
endpackage

// File: rtl/flit_acc.sv
`timescale 1ns/1ps
module flit_acc #(
  parameter int PAYLOAD = 242,
  parameter logic [63:0] POLY = flit_pkg::CRC64_POLY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic [7:0] byte_in,
  output logic [$clog2(PAYLOAD + flit_pkg::CRC_BYTES + flit_pkg::CHK_BYTES)-1:0] pos,
  output logic [63:0] crc,
  output logic [47:0] chk,
  output logic last
);
  import flit_pkg::*;
  localparam int CHK_LO = PAYLOAD + CRC_BYTES;
  localparam int FLIT = CHK_LO + CHK_BYTES;
  localparam int POS_W = $clog2(FLIT);
  localparam logic [POS_W-1:0] P_END = POS_W'(PAYLOAD);
  localparam logic [POS_W-1:0] C_END = POS_W'(CHK_LO);
  localparam logic [POS_W-1:0] F_LAST = POS_W'(FLIT - 1);

  logic [1:0] grp;
  logic [2:0] third;
  logic [2:0][7:0] par, rpar;

  assign last = step && (pos == F_LAST);
  assign chk = {par[0], rpar[0], par[1], rpar[1], par[2], rpar[2]};

  always_ff @(posedge clk) begin
    if (!rst_n || last) begin
      pos <= '0; grp <= '0; third <= '0;
      crc <= '1; par <= '0; rpar <= '0;
    end else if (step) begin
      pos <= pos + 1'b1;
      if (grp == 2'd2) begin
        grp <= 2'd0;
        third <= third + 1'b1;
      end else begin
        grp <= grp + 1'b1;
      end
      if (pos < P_END) crc <= crc64_byte(crc, byte_in, POLY);
      if (pos < C_END) begin
        par[grp] <= par[grp] ^ byte_in;
        rpar[grp] <= rpar[grp] ^ rotl8(byte_in, third);
      end
    end
  end

  AST_FLIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (pos == '0) && (crc == '1)); // R1
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos)); // R1
  AST_GROUP_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pos) % 3) == 32'(grp)); // R6
endmodule

// File: rtl/flit_tx.sv
`timescale 1ns/1ps
module flit_tx #(
  parameter int PAYLOAD = 242,
  parameter logic [63:0] POLY = flit_pkg::CRC64_POLY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic [7:0] in_data,
  output logic in_ready,
  output logic tx_valid,
  output logic [7:0] tx_data,
  input  logic tx_ready
);
  import flit_pkg::*;
  localparam int CHK_LO = PAYLOAD + CRC_BYTES;
  localparam int POS_W = $clog2(CHK_LO + CHK_BYTES);
  localparam logic [POS_W-1:0] P_END = POS_W'(PAYLOAD);
  localparam logic [POS_W-1:0] C_END = POS_W'(CHK_LO);

  logic [POS_W-1:0] pos;
  logic [63:0] crc;
  logic [47:0] chk;
  logic flit_last, tx_fire, pad, in_payload, in_crc, use_in;
  logic [7:0] crc_b, chk_b;
  logic [2:0] csel, ksel;

  flit_acc #(.PAYLOAD(PAYLOAD), .POLY(POLY)) u_acc (
    .clk(clk), .rst_n(rst_n), .step(tx_fire), .byte_in(tx_data),
    .pos(pos), .crc(crc), .chk(chk), .last(flit_last));

  assign in_payload = pos < P_END;
  assign in_crc = !in_payload && (pos < C_END);
  assign use_in = in_payload && !pad && in_valid;
  assign tx_valid = (pos == '0) ? in_valid : 1'b1;
  assign tx_fire = tx_valid && tx_ready;
  assign in_ready = tx_ready && in_payload && !pad;
  assign csel = 3'(pos - P_END);
  assign ksel = 3'(pos - C_END);

  always_comb begin
    crc_b = '0;
    for (int k = 0; k < CRC_BYTES; k++)
      if (csel == 3'(k)) crc_b = crc[63-8*k -: 8];
    chk_b = '0;
    for (int k = 0; k < CHK_BYTES; k++)
      if (ksel == 3'(k)) chk_b = chk[47-8*k -: 8];
  end

  assign tx_data = in_payload ? (use_in ? in_data : 8'h00)
                              : (in_crc ? crc_b : chk_b);

  always_ff @(posedge clk) begin
    if (!rst_n) pad <= 1'b0;
    else if (flit_last) pad <= 1'b0;
    else if (tx_fire && in_payload && !use_in) pad <= 1'b1;
  end

  AST_PAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pad && !flit_last |=> pad); // R5
  AST_PAD_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    pad |-> !in_ready); // R5
  AST_NO_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == '0) && !in_valid |-> !tx_valid); // R4
endmodule

// File: rtl/flit_rx.sv
`timescale 1ns/1ps
module flit_rx #(
  parameter int PAYLOAD = 242,
  parameter logic [63:0] POLY = flit_pkg::CRC64_POLY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  input  logic [7:0] rx_data,
  output logic rx_ready,
  output logic pl_valid,
  output logic [7:0] pl_data,
  input  logic pl_ready,
  output logic crc_ok,
  output logic crc_err,
  output logic fec_ok,
  output logic fec_err
);
  import flit_pkg::*;
  localparam int CHK_LO = PAYLOAD + CRC_BYTES;
  localparam int POS_W = $clog2(CHK_LO + CHK_BYTES);
  localparam logic [POS_W-1:0] P_END = POS_W'(PAYLOAD);
  localparam logic [POS_W-1:0] C_END = POS_W'(CHK_LO);

  logic [POS_W-1:0] pos;
  logic [63:0] crc, rcv_crc;
  logic [47:0] chk;
  logic [39:0] rcv_chk;
  logic flit_last, rx_fire, in_payload, crc_match, chk_match;

  flit_acc #(.PAYLOAD(PAYLOAD), .POLY(POLY)) u_acc (
    .clk(clk), .rst_n(rst_n), .step(rx_fire), .byte_in(rx_data),
    .pos(pos), .crc(crc), .chk(chk), .last(flit_last));

  assign in_payload = pos < P_END;
  assign rx_ready = in_payload ? pl_ready : 1'b1;
  assign rx_fire = rx_valid && rx_ready;
  assign pl_valid = rx_valid && in_payload;
  assign pl_data = rx_data;
  assign crc_match = rcv_crc == crc;
  assign chk_match = {rcv_chk, rx_data} == chk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcv_crc <= '0; rcv_chk <= '0;
      crc_ok <= 1'b0; crc_err <= 1'b0; fec_ok <= 1'b0; fec_err <= 1'b0;
    end else begin
      if (rx_fire && !in_payload && pos < C_END) rcv_crc <= {rcv_crc[55:0], rx_data};
      if (rx_fire && pos >= C_END && !flit_last) rcv_chk <= {rcv_chk[31:0], rx_data};
      crc_ok  <= flit_last && crc_match;
      crc_err <= flit_last && !crc_match;
      fec_ok  <= flit_last && chk_match;
      fec_err <= flit_last && !chk_match;
    end
  end

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({crc_ok, crc_err}) && $onehot0({fec_ok, fec_err})); // R8
  AST_VERDICT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_ok || crc_err) |=> !(crc_ok || crc_err)); // R8
  AST_VERDICT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_ok || crc_err) == (fec_ok || fec_err)); // R8
endmodule

// File: rtl/flit_framer.sv
`timescale 1ns/1ps
module flit_framer #(
  parameter int PAYLOAD_BYTES = 242,
  parameter logic [63:0] CRC_POLY = flit_pkg::CRC64_POLY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic [7:0] in_data,
  output logic in_ready,
  output logic tx_valid,
  output logic [7:0] tx_data,
  input  logic tx_ready,
  input  logic rx_valid,
  input  logic [7:0] rx_data,
  output logic rx_ready,
  output logic pl_valid,
  output logic [7:0] pl_data,
  input  logic pl_ready,
  output logic crc_ok,
  output logic crc_err,
  output logic fec_ok,
  output logic fec_err
);
  flit_tx #(.PAYLOAD(PAYLOAD_BYTES), .POLY(CRC_POLY)) u_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready));

  flit_rx #(.PAYLOAD(PAYLOAD_BYTES), .POLY(CRC_POLY)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .pl_valid(pl_valid), .pl_data(pl_data),
    .pl_ready(pl_ready), .crc_ok(crc_ok), .crc_err(crc_err),
    .fec_ok(fec_ok), .fec_err(fec_err));

  AST_TX_FIRE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> tx_valid && (tx_data == in_data)); // R2
endmodule

// File: tb/test_flit_framer.sv
`timescale 1ns/1ps
module test_flit_framer;
  localparam int PL = 242;
  localparam int FL = 256;
  localparam logic [63:0] POLY = 64'h42F0E1EBA9EA3693;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic in_valid, pl_ready, corrupt;
  logic [7:0] in_data;
  wire in_ready, tx_valid, tx_ready, rx_ready, pl_valid;
  wire crc_ok, crc_err, fec_ok, fec_err;
  wire [7:0] tx_data, pl_data;
  wire rx_valid = tx_valid;
  wire [7:0] rx_data = tx_data ^ {7'b0, corrupt};
  assign tx_ready = rx_ready;

  flit_framer i_flit_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .pl_valid(pl_valid), .pl_data(pl_data),
    .pl_ready(pl_ready), .crc_ok(crc_ok), .crc_err(crc_err),
    .fec_ok(fec_ok), .fec_err(fec_err));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] stream [0:1023];
  logic [7:0] expf [0:1023];
  logic [7:0] txr [0:1023];
  logic [7:0] plr [0:1023];
  bit rc_ok [0:7];
  bit rf_ok [0:7];
  int nflit, ntx, npl, nres;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_crc(input int f);
    logic [63:0] c = '1;
    for (int i = 0; i < PL; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[63] ^ expf[f*FL+i][b];
        c = {c[62:0], 1'b0};
        if (fb) c = c ^ POLY;
      end
    return c;
  endfunction

  function automatic logic [47:0] ref_chk(input int f);
    logic [7:0] x [3];
    logic [7:0] r [3];
    for (int g = 0; g < 3; g++) begin x[g] = 0; r[g] = 0; end
    for (int i = 0; i < PL + 8; i++) begin
      logic [15:0] w;
      w = {expf[f*FL+i], expf[f*FL+i]} << ((i / 3) % 8);
      x[i%3] = x[i%3] ^ expf[f*FL+i];
      r[i%3] = r[i%3] ^ w[15:8];
    end
    return {x[0], r[0], x[1], r[1], x[2], r[2]};
  endfunction

  task automatic add_segment(input int start, input int len);
    for (int s = 0; s < len; s += PL) begin
      logic [63:0] c;
      logic [47:0] k;
      for (int j = 0; j < PL; j++)
        expf[nflit*FL+j] = (s + j < len) ? stream[start+s+j] : 8'h00;
      c = ref_crc(nflit);
      for (int j = 0; j < 8; j++) expf[nflit*FL+PL+j] = c[63-8*j -: 8];
      k = ref_chk(nflit);
      for (int j = 0; j < 6; j++) expf[nflit*FL+PL+8+j] = k[47-8*j -: 8];
      nflit++;
    end
  endtask

  task automatic run(input int len, input int gap_at, input int cflit,
                     input int cpos, input int plmode, input int seed,
                     input string lbl);
    int ip = 0, gap_left = 0, idle = 0;
    bit gap_done = 0;
    for (int k = 0; k < len; k++) stream[k] = 8'((k * 7 + seed * 13 + (k >> 3)) & 255);
    nflit = 0; ntx = 0; npl = 0; nres = 0;
    if (gap_at > 0 && gap_at < len) begin
      add_segment(0, gap_at);
      add_segment(gap_at, len - gap_at);
    end else add_segment(0, len);
    while (idle < 4) begin
      @(negedge clk);
      cyc++;
      if (!gap_done && gap_at > 0 && ip == gap_at) begin gap_left = 4; gap_done = 1; end
      in_valid = (ip < len) && (gap_left == 0);
      in_data = stream[(ip < len) ? ip : 0];
      pl_ready = (gap_left > 0 || plmode == 0) ? 1'b1 : (cyc % 3 != 0);
      corrupt = (cflit >= 0) && (ntx == cflit * FL + cpos);
      #1;
      if (crc_ok || crc_err) begin rc_ok[nres] = crc_ok; rf_ok[nres] = fec_ok; nres++; end
      if (tx_valid && tx_ready) begin txr[ntx] = tx_data; ntx++; end
      if (pl_valid && pl_ready) begin plr[npl] = pl_data; npl++; end
      if (in_valid && in_ready) ip++;
      if (gap_left > 0) gap_left--;
      if (ip >= len && !tx_valid) idle++; else idle = 0;
    end
    in_valid = 1'b0;
    corrupt = 1'b0;
    // R1: whole units only
    check(ntx == nflit * FL, "R1", "transmitted byte count", 64'(ntx), 64'(nflit * FL));
    for (int f = 0; f < nflit; f++) begin
      int bp = -1, bc = -1, bk = -1;
      for (int j = 0; j < FL; j++)
        if (txr[f*FL+j] !== expf[f*FL+j]) begin
          if (j < PL && bp < 0) bp = j;
          else if (j >= PL && j < PL + 8 && bc < 0) bc = j;
          else if (j >= PL + 8 && bk < 0) bk = j;
        end
      check(bp < 0, lbl, "payload byte", 64'(txr[f*FL+(bp<0?0:bp)]), 64'(expf[f*FL+(bp<0?0:bp)]));
      check(bc < 0, "R3", "crc byte", 64'(txr[f*FL+(bc<0?PL:bc)]), 64'(expf[f*FL+(bc<0?PL:bc)]));
      check(bk < 0, "R6", "check byte", 64'(txr[f*FL+(bk<0?PL+8:bk)]), 64'(expf[f*FL+(bk<0?PL+8:bk)]));
      if (f < nres) begin
        bit ec, ef;
        ec = !(f == cflit && cpos < PL + 8);
        ef = !(f == cflit);
        check(rc_ok[f] == ec, "R9", "crc verdict ok", 64'(rc_ok[f]), 64'(ec));
        check(rf_ok[f] == ef, "R9", "check-byte verdict ok", 64'(rf_ok[f]), 64'(ef));
      end
    end
    check(nres == nflit, "R8", "verdict count", 64'(nres), 64'(nflit));
    check(npl == nflit * PL, "R7", "payload out count", 64'(npl), 64'(nflit * PL));
    begin
      int bad = -1;
      for (int f = 0; f < nflit; f++)
        for (int j = 0; j < PL; j++) begin
          logic [7:0] e;
          e = expf[f*FL+j] ^ ((f == cflit && j == cpos) ? 8'h01 : 8'h00);
          if (bad < 0 && plr[f*PL+j] !== e) bad = f * PL + j;
        end
      check(bad < 0, "R7", "payload out first bad index", 64'(bad), 64'hFFFF_FFFF_FFFF_FFFF);
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    in_valid = 1'b0; in_data = 8'h00; pl_ready = 1'b1; corrupt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R4: no unit without input; R8: no verdict after reset
    check(!tx_valid, "R4", "tx_valid idle after reset", 64'(tx_valid), 0);
    check(!pl_valid && !crc_ok && !crc_err && !fec_ok && !fec_err, "R8",
          "receive outputs quiet after reset", 64'({pl_valid, crc_ok, crc_err, fec_ok, fec_err}), 0);
    run(60, 0, -1, 0, 0, 11, "R2");
    run(500, 0, -1, 0, 1, 37, "R10");
    run(242, 0, -1, 0, 0, 5, "R4");
    check(ntx == FL, "R4", "exact-payload stream gives one unit", 64'(ntx), 64'(FL));
    run(130, 100, -1, 0, 0, 71, "R5");
    run(30, 0, 0, 245, 0, 3, "R2");
    run(30, 0, 0, 252, 0, 9, "R2");
    run(300, 0, 1, 17, 0, 21, "R2");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule